// File: doc/BRIEF.md
# Per-Hart Timer and Software-Interrupt Unit

This block gives each hart of a small multi-hart processor two interrupt sources. The first is a timer interrupt, taken from a shared 64-bit time counter and a 64-bit compare value kept for each hart. The second is a software interrupt, which one hart raises for another by writing a one-bit flag. All state sits behind a plain 32-bit register port made of address, write enable, write data, byte strobes and read data. Reads are combinational and return the live value in the same cycle. Writes take effect at the next rising clock edge.

The time counter moves forward by one on every cycle in which the external tick enable is high. Software reads it as two 32-bit halves. A carry between the two reads shows up as a change in the high half, so software reads the high half again to catch it. Each hart's timer line is a level. It stays high while the counter is at or above that hart's compare value. Software clears it by writing a later compare value. Each hart's software line follows a flag that software sets and clears.

Top module: `hart_tmr_swi`

## Requirements
- R1: After reset, the counter reads 0 and every compare register reads 0xFFFFFFFF in both halves. Every software flag reads 0, and all timer and software lines are low.
- R2: A write to offset 4*h with byte strobe 0 set stores wdata bit 0 as hart h's software flag, which drives sip_o[h]. A read of that word returns the flag in bit 0 and zero in bits 31..1.
- R3: Hart h's compare register has its low half at 0x4000+8*h and its high half at 0x4004+8*h. Each half is written and read on its own, and a write touches no other hart.
- R4: The counter rises by exactly one on each clock edge where tick_i is high and no counter write happens. It holds its value when tick_i is low.
- R5: A read at 0xBFF8 returns the live low half of the counter and a read at 0xBFFC returns the live high half. A carry out of the low half shows up in the high half.
- R6: Writes at 0xBFF8 and 0xBFFC load the matching counter half. In a cycle with a counter write, the write takes precedence over tick_i.
- R7: tip_o[h] is high exactly when the counter is greater than or equal to hart h's compare value, compared as unsigned 64-bit numbers. The comparison uses the new compare value from the cycle after it is written.
- R8: A read at any address outside the mapped words returns zero, and a write there changes no state. Words for hart indices at or above NUM_HARTS count as unmapped.
- R9: The counter wraps from 0xFFFFFFFF_FFFFFFFF to zero on a tick.
- R10: A write updates only the byte lanes whose strobe is set. A software-flag write needs strobe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter tick enable |
| addr_i | input | ADDR_W | Byte address of the register word |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes for the write |
| rdata_o | output | 32 | Combinational read data |
| tip_o | output | NUM_HARTS | Timer interrupt line, one per hart |
| sip_o | output | NUM_HARTS | Software interrupt line, one per hart |

## Verification
The assertions assume that addr_i, we_i, wdata_i, be_i and tick_i are stable around each rising edge. They also assume a write asserts we_i for exactly one edge. The bench changes every input only on the falling edge and holds each write for a single cycle. It keeps tick_i low except in tick bursts or in a deliberate write-plus-tick cycle, so the expected counter value is always known exactly.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned BE_W   = BUS_W / 8;
  localparam int unsigned TIME_W = 64;

  localparam int unsigned SWI_BASE = 32'h0000;
  localparam int unsigned CMP_BASE = 32'h4000;
  localparam int unsigned CNT_LO   = 32'hBFF8;
  localparam int unsigned CNT_HI   = 32'hBFFC;

  function automatic logic [BUS_W-1:0] merge_be(logic [BUS_W-1:0] old_v,
                                                logic [BUS_W-1:0] new_v,
                                                logic [BE_W-1:0]  be);
    logic [BUS_W-1:0] res;
    res = old_v;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/hts_decode.sv
module hts_decode
  import hts_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 2,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_HARTS-1:0] swi_sel_o,
  output logic [NUM_HARTS-1:0] cmp_lo_sel_o,
  output logic [NUM_HARTS-1:0] cmp_hi_sel_o,
  output logic                 cnt_lo_sel_o,
  output logic                 cnt_hi_sel_o,
  output logic                 hit_o
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign swi_sel_o[h]    = addr_i == ADDR_W'(SWI_BASE + 4 * h);
    assign cmp_lo_sel_o[h] = addr_i == ADDR_W'(CMP_BASE + 8 * h);
    assign cmp_hi_sel_o[h] = addr_i == ADDR_W'(CMP_BASE + 8 * h + 4);
  end

  assign cnt_lo_sel_o = addr_i == ADDR_W'(CNT_LO);
  assign cnt_hi_sel_o = addr_i == ADDR_W'(CNT_HI);
  assign hit_o = (|swi_sel_o) | (|cmp_lo_sel_o) | (|cmp_hi_sel_o)
               | cnt_lo_sel_o | cnt_hi_sel_o;
endmodule

// File: rtl/hts_counter.sv
module hts_counter
  import hts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [TIME_W-1:0] cnt_o
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      // a software load overrides the tick for that cycle
      if (wr_lo_i) cnt_q[BUS_W-1:0]      <= merge_be(cnt_q[BUS_W-1:0], wdata_i, be_i);
      if (wr_hi_i) cnt_q[TIME_W-1:BUS_W] <= merge_be(cnt_q[TIME_W-1:BUS_W], wdata_i, be_i);
    end else if (tick_i) begin
      cnt_q <= cnt_q + TIME_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_lo_i && !wr_hi_i) |=> cnt_o == $past(cnt_o) + TIME_W'(1));

  p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));
endmodule

// File: rtl/hts_hart_slot.sv
module hts_hart_slot
  import hts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] cnt_i,
  input  logic              swi_wr_i,
  input  logic              swi_d_i,
  input  logic              cmp_wr_lo_i,
  input  logic              cmp_wr_hi_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [TIME_W-1:0] cmp_o,
  output logic              swi_o,
  output logic              tip_o
);
  logic [TIME_W-1:0] cmp_q;
  logic              swi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      swi_q <= 1'b0;
    end else begin
      if (cmp_wr_lo_i) cmp_q[BUS_W-1:0]      <= merge_be(cmp_q[BUS_W-1:0], wdata_i, be_i);
      if (cmp_wr_hi_i) cmp_q[TIME_W-1:BUS_W] <= merge_be(cmp_q[TIME_W-1:BUS_W], wdata_i, be_i);
      if (swi_wr_i)    swi_q <= swi_d_i;
    end
  end

  assign cmp_o = cmp_q;
  assign swi_o = swi_q;
  assign tip_o = cnt_i >= cmp_q;

  p_swi_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_wr_i |=> swi_o == $past(swi_d_i));

  p_swi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swi_wr_i |=> $stable(swi_o));

  p_cmp_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmp_wr_lo_i || cmp_wr_hi_i) |=> $stable(cmp_o));
endmodule

// File: rtl/hart_tmr_swi.sv
module hart_tmr_swi
  import hts_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 2,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [31:0]          wdata_i,
  input  logic [3:0]           be_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_HARTS-1:0] tip_o,
  output logic [NUM_HARTS-1:0] sip_o
);
  logic [NUM_HARTS-1:0] swi_sel, cmp_lo_sel, cmp_hi_sel;
  logic                 cnt_lo_sel, cnt_hi_sel, hit;
  logic [TIME_W-1:0]    cnt;
  logic [TIME_W-1:0]    cmp_q [NUM_HARTS];

  hts_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i       (addr_i),
    .swi_sel_o    (swi_sel),
    .cmp_lo_sel_o (cmp_lo_sel),
    .cmp_hi_sel_o (cmp_hi_sel),
    .cnt_lo_sel_o (cnt_lo_sel),
    .cnt_hi_sel_o (cnt_hi_sel),
    .hit_o        (hit)
  );

  hts_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_lo_i (we_i && cnt_lo_sel),
    .wr_hi_i (we_i && cnt_hi_sel),
    .wdata_i (wdata_i),
    .be_i    (be_i),
    .cnt_o   (cnt)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    hts_hart_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cnt_i       (cnt),
      .swi_wr_i    (we_i && swi_sel[h] && be_i[0]),
      .swi_d_i     (wdata_i[0]),
      .cmp_wr_lo_i (we_i && cmp_lo_sel[h]),
      .cmp_wr_hi_i (we_i && cmp_hi_sel[h]),
      .wdata_i     (wdata_i),
      .be_i        (be_i),
      .cmp_o       (cmp_q[h]),
      .swi_o       (sip_o[h]),
      .tip_o       (tip_o[h])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (cnt_lo_sel) rdata_o = cnt[BUS_W-1:0];
    if (cnt_hi_sel) rdata_o = cnt[TIME_W-1:BUS_W];
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (swi_sel[h])    rdata_o = {{(BUS_W-1){1'b0}}, sip_o[h]};
      if (cmp_lo_sel[h]) rdata_o = cmp_q[h][BUS_W-1:0];
      if (cmp_hi_sel[h]) rdata_o = cmp_q[h][TIME_W-1:BUS_W];
    end
  end

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> rdata_o == '0);

  p_sel_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({swi_sel, cmp_lo_sel, cmp_hi_sel, cnt_lo_sel, cnt_hi_sel}));
endmodule

// File: tb/sim_hart_tmr_swi.sv
`timescale 1ns/1ps
module sim_hart_tmr_swi;
  localparam int NH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic [NH-1:0] tip, sip;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 tip, 2 sip
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  hart_tmr_swi #(.NUM_HARTS(NH), .ADDR_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .tip_o(tip), .sip_o(sip)
  );

  // monitor: compare queued expectations mid-cycle
  initial forever begin
    @(negedge clk);
    #3;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {31'b0, tip[it.idx]};
        default: act = {31'b0, sip[it.idx]};
      endcase
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    we = 1'b0; tick = 1'b0; addr = a;
    q.push_back('{0, 0, e, t});
  endtask

  task automatic chk(input int kind, input int idx, input logic e, input string t);
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    q.push_back('{kind, idx, {31'b0, e}, t});
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d,
                    input logic [3:0] b, input logic tk);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; be = b; tick = tk;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    we = 1'b0; tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #23 rst_n = 1'b1;

    rd(16'hBFF8, 32'h0, "R1 cnt lo");
    rd(16'hBFFC, 32'h0, "R1 cnt hi");
    rd(16'h4000, 32'hFFFFFFFF, "R1 cmp0 lo");
    rd(16'h400C, 32'hFFFFFFFF, "R1 cmp1 hi");
    rd(16'h0000, 32'h0, "R1 swi0");
    chk(1, 0, 1'b0, "R1 tip0");
    chk(2, 1, 1'b0, "R1 sip1");

    wr(16'h0000, 32'hFFFFFFFF, 4'hF, 1'b0);
    rd(16'h0000, 32'h1, "R2 swi0 reads bit0 only");
    chk(2, 0, 1'b1, "R2 sip0 set");
    chk(2, 1, 1'b0, "R2 sip1 untouched");
    wr(16'h0004, 32'h1, 4'b1110, 1'b0);
    chk(2, 1, 1'b0, "R10 swi needs lane0");
    wr(16'h0004, 32'h1, 4'hF, 1'b0);
    chk(2, 1, 1'b1, "R2 sip1 set");
    wr(16'h0000, 32'h0, 4'hF, 1'b0);
    chk(2, 0, 1'b0, "R2 sip0 cleared");
    rd(16'h0004, 32'h1, "R2 swi1 read");

    wr(16'h4008, 32'h10, 4'hF, 1'b0);
    wr(16'h400C, 32'h0, 4'hF, 1'b0);
    rd(16'h4008, 32'h10, "R3 cmp1 lo");
    rd(16'h400C, 32'h0, "R3 cmp1 hi");
    rd(16'h4000, 32'hFFFFFFFF, "R3 cmp0 untouched");
    chk(1, 1, 1'b0, "R7 tip1 below");

    tick_n(15);
    rd(16'hBFF8, 32'd15, "R4 count 15");
    chk(1, 1, 1'b0, "R7 tip1 one below");
    tick_n(1);
    chk(1, 1, 1'b1, "R7 tip1 at equal");
    rd(16'hBFF8, 32'd16, "R4 count 16");
    rd(16'hBFF8, 32'd16, "R4 hold without tick");

    wr(16'h4008, 32'h20, 4'hF, 1'b0);
    chk(1, 1, 1'b0, "R7 tip1 cleared by later compare");

    wr(16'hBFFC, 32'h1, 4'hF, 1'b0);
    rd(16'hBFFC, 32'h1, "R6 cnt hi loaded");
    rd(16'hBFF8, 32'h10, "R6 cnt lo kept");
    chk(1, 1, 1'b1, "R7 tip1 high half larger");

    wr(16'h4004, 32'h80000000, 4'hF, 1'b0);
    wr(16'h4000, 32'h0, 4'hF, 1'b0);
    chk(1, 0, 1'b0, "R7 tip0 below msb compare");
    wr(16'hBFFC, 32'h80000000, 4'hF, 1'b0);
    chk(1, 0, 1'b1, "R7 tip0 unsigned compare");

    wr(16'hBFF8, 32'h5, 4'hF, 1'b1);
    rd(16'hBFF8, 32'h5, "R6 write beats tick");

    wr(16'hBFF8, 32'hFFFFFFFF, 4'hF, 1'b0);
    wr(16'hBFFC, 32'h2, 4'hF, 1'b0);
    tick_n(1);
    rd(16'hBFFC, 32'h3, "R5 carry into hi");
    rd(16'hBFF8, 32'h0, "R5 lo after carry");

    wr(16'hBFFC, 32'hFFFFFFFF, 4'hF, 1'b0);
    wr(16'hBFF8, 32'hFFFFFFFF, 4'hF, 1'b0);
    tick_n(1);
    rd(16'hBFFC, 32'h0, "R9 wrap hi");
    rd(16'hBFF8, 32'h0, "R9 wrap lo");

    wr(16'h4008, 32'hFFFFFFAB, 4'b0001, 1'b0);
    rd(16'h4008, 32'h000000AB, "R10 lane0 only");
    wr(16'h400C, 32'h12345678, 4'b1000, 1'b0);
    rd(16'h400C, 32'h12000000, "R10 lane3 only");

    wr(16'h8000, 32'hDEADBEEF, 4'hF, 1'b0);
    rd(16'h8000, 32'h0, "R8 unmapped read");
    rd(16'h0008, 32'h0, "R8 swi past last hart");
    wr(16'h4010, 32'h0, 4'hF, 1'b0);
    rd(16'h4000, 32'h0, "R8 cmp0 lo kept");
    rd(16'h4004, 32'h80000000, "R8 cmp0 hi kept");
    rd(16'h400C, 32'h12000000, "R8 cmp1 hi kept");
    rd(16'hBFF8, 32'h0, "R8 cnt unchanged");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule